// File: doc/BRIEF.md
# Five-Port I2C Segment Hub

This block joins five I2C segments into one logical bus, with a single repeater delay between any two segments. For every port it takes the sampled level of the port's SDA and SCL lines and produces an open-drain pull-down request for each line. A LOW that a device places on an enabled segment is copied onto every other enabled segment, and is released when that device lets go. There is no fixed direction: masters and slaves may sit on any port. The two lines are handled by two identical, independent line controllers.

To stop the hub's own repeated LOW from holding the bus down for ever, each line controller records the one port whose device started the LOW. That port is the owner. The inputs of every port the hub is driving are ignored until the owner's line is HIGH again. After a release, those ports stay ignored for a short hold-off while their synchronized levels recover. A device that is still holding one of them LOW after that window then takes ownership. This is how the hub hands over during arbitration and clock stretching.

Port 0 is always connected. Ports 1 to 4 each have an enable request. A request is applied to the port's effective enable only while the whole bus is idle and the requested port's own lines are HIGH; at any other time the previous effective enable is kept.

Top module: `i2c_hub_repeater`

## Requirements
- R1: While reset is held and in the first cycle after it, every bit of `sda_pull` and `scl_pull` is 0 (1 means pull the line LOW).
- R2: When a device pulls a line LOW on an enabled port and no port owns that line, the pull outputs of that line become set on every other enabled port after the third rising clock edge following the change, and not after the second.
- R3: Repeating is non-inverting and per line. The owner port's own pull bit stays 0, and a LOW on SDA never sets any `scl_pull` bit (and the reverse).
- R4: When the owner's line returns HIGH, all pull bits of that line clear after the third rising edge following the change, and are still set after the second.
- R5: After a release, the ports that were being driven are ignored for SYNC_STAGES+1 cycles, so the released bus stays released. A device still holding one of those ports LOW becomes the new owner after the seventh rising edge following the owner's release.
- R6: If several enabled ports pull the same free line LOW in the same cycle, the lowest-numbered port becomes the owner.
- R7: A port whose effective enable is 0 has its line levels ignored, and its pull bits are never set.
- R8: Port 0 is always enabled. Its LOW is repeated to the enabled ports, and a LOW on any enabled port is repeated to port 0.
- R9: `port_en_req[k]` controls port k+1. The request is copied into that port's effective enable only on a cycle in which:
  - neither line has an owner or a running hold-off;
  - every enabled line is HIGH;
  - the port's own SDA and SCL are HIGH.
  On any other cycle the effective enable is held.
- R10: A port holding SCL LOW (clock stretching) stays its owner for as long as it holds it, and the other enabled ports stay pulled LOW for that whole time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sda_in | input | 5 | Sampled SDA level of each port (bit n = port n) |
| scl_in | input | 5 | Sampled SCL level of each port |
| port_en_req | input | 4 | Enable requests for ports 1 to 4 (bit k = port k+1) |
| sda_pull | output | 5 | 1 = drive that port's SDA LOW |
| scl_pull | output | 5 | 1 = drive that port's SCL LOW |

## Verification
Every input passes through a two-stage synchronizer before the owner register, so a new LOW shows up on the pull outputs after the third rising edge. A release clears them after the third edge, and a hand-off to a port that is still held LOW lands after the seventh. The bench changes device pulls at a falling edge and reads the outputs at a falling edge after counted rising edges. It checks both the cycle before each result is due and the cycle the result arrives. Changes of the enable request are checked by what the repeated pattern looks like on the next LOW event, both when the request arrives while the bus is busy and when the bus is idle.

// File: rtl/hub_pkg.sv
package hub_pkg;

    localparam int unsigned HUB_PORTS    = 5;
    localparam int unsigned HUB_IDXW     = $clog2(HUB_PORTS);
    localparam int unsigned HUB_SYNC_DEF = 2;

    typedef logic [HUB_PORTS-1:0] port_vec_t;
    typedef logic [HUB_IDXW-1:0]  port_idx_t;

    typedef enum logic [1:0] {
        LINE_FREE  = 2'd0,
        LINE_OWNED = 2'd1,
        LINE_HOLD  = 2'd2
    } line_state_e;

    typedef struct packed {
        line_state_e state;
        port_idx_t   idx;
    } line_ctx_t;

    function automatic port_idx_t lowest_port(port_vec_t v);
        port_idx_t r;
        r = '0;
        for (int i = HUB_PORTS - 1; i >= 0; i--) begin
            if (v[i]) r = port_idx_t'(i);
        end
        return r;
    endfunction

    function automatic port_vec_t port_bit(port_idx_t i);
        return port_vec_t'(1) << i;
    endfunction

    function automatic port_vec_t below_mask(port_idx_t i);
        return port_bit(i) - port_vec_t'(1);
    endfunction

endpackage

// File: rtl/hub_sync.sv
module hub_sync #(
    parameter int unsigned WIDTH  = 10,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < int'(STAGES); s++) stg[s] <= '1;
        end else begin
            stg[0] <= d;
            for (int s = 1; s < int'(STAGES); s++) stg[s] <= stg[s-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/hub_line_ctrl.sv
module hub_line_ctrl
    import hub_pkg::*;
#(
    parameter int unsigned HOLD_CYC = 3
) (
    input  logic      clk,
    input  logic      rst,
    input  port_vec_t lvl,
    input  port_vec_t en,
    output port_vec_t drive,
    output logic      busy
);
    localparam int unsigned CNTW = $clog2(HOLD_CYC + 1);

    line_ctx_t        ctx_q, ctx_d;
    port_vec_t        mask_q, mask_d;
    logic [CNTW-1:0]  cnt_q, cnt_d;
    port_vec_t        pulling, eligible;

    assign pulling  = en & ~lvl;
    assign eligible = (ctx_q.state == LINE_HOLD) ? (pulling & ~mask_q) : pulling;
    assign drive    = (ctx_q.state == LINE_OWNED) ? (en & ~port_bit(ctx_q.idx)) : '0;
    assign busy     = (ctx_q.state != LINE_FREE);

    always_comb begin
        ctx_d  = ctx_q;
        mask_d = mask_q;
        cnt_d  = cnt_q;
        unique case (ctx_q.state)
            LINE_FREE: begin
                if (|eligible) begin
                    ctx_d.state = LINE_OWNED;
                    ctx_d.idx   = lowest_port(eligible);
                end
            end
            LINE_OWNED: begin
                if (lvl[ctx_q.idx] || !en[ctx_q.idx]) begin
                    ctx_d.state = LINE_HOLD;
                    mask_d      = drive;
                    cnt_d       = CNTW'(HOLD_CYC);
                end
            end
            LINE_HOLD: begin
                if (|eligible) begin
                    ctx_d.state = LINE_OWNED;
                    ctx_d.idx   = lowest_port(eligible);
                    cnt_d       = '0;
                end else if (cnt_q <= CNTW'(1)) begin
                    ctx_d.state = LINE_FREE;
                    cnt_d       = '0;
                end else begin
                    cnt_d = cnt_q - CNTW'(1);
                end
            end
            default: begin
                ctx_d.state = LINE_FREE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctx_q  <= '{state: LINE_FREE, idx: '0};
            mask_q <= '0;
            cnt_q  <= '0;
        end else begin
            ctx_q  <= ctx_d;
            mask_q <= mask_d;
            cnt_q  <= cnt_d;
        end
    end

    // R2: a free line with a LOW on an enabled port is owned next cycle
    assert_claim_R2: assert property (@(posedge clk) disable iff (rst)
        (ctx_q.state == LINE_FREE && (|pulling)) |=> (ctx_q.state == LINE_OWNED));

    // R6: no lower-numbered port was pulling when ownership was taken
    assert_lowest_wins_R6: assert property (@(posedge clk) disable iff (rst)
        (ctx_q.state == LINE_FREE && (|pulling)) |=>
        (($past(pulling) & below_mask(ctx_q.idx)) == '0));

    // R10: owner keeps the line while its input stays LOW
    assert_owner_kept_R10: assert property (@(posedge clk) disable iff (rst)
        (ctx_q.state == LINE_OWNED && !lvl[ctx_q.idx] && en[ctx_q.idx]) |=>
        (ctx_q.state == LINE_OWNED && $stable(ctx_q.idx)));

    // R4: owner HIGH again means every drive is off next cycle
    assert_release_R4: assert property (@(posedge clk) disable iff (rst)
        (ctx_q.state == LINE_OWNED && lvl[ctx_q.idx]) |=> (drive == '0));
endmodule

// File: rtl/hub_en_qual.sv
module hub_en_qual
    import hub_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [HUB_PORTS-2:0] req,
    input  port_vec_t            sda_lvl,
    input  port_vec_t            scl_lvl,
    input  logic                 sda_busy,
    input  logic                 scl_busy,
    output port_vec_t            eff
);
    logic [HUB_PORTS-2:0] eff_q, upd;
    logic                 bus_idle;

    assign eff = {eff_q, 1'b1};

    assign bus_idle = !sda_busy && !scl_busy &&
                      (&(sda_lvl | ~eff)) && (&(scl_lvl | ~eff));

    for (genvar p = 1; p < HUB_PORTS; p++) begin : g_upd
        assign upd[p-1] = bus_idle & sda_lvl[p] & scl_lvl[p];
    end

    always_ff @(posedge clk) begin
        if (rst) eff_q <= '0;
        else     eff_q <= (eff_q & ~upd) | (req & upd);
    end

    // R9: effective enables are frozen while the bus is not idle
    assert_en_frozen_R9: assert property (@(posedge clk) disable iff (rst)
        !bus_idle |=> $stable(eff_q));
endmodule

// File: rtl/i2c_hub_repeater.sv
module i2c_hub_repeater
    import hub_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = HUB_SYNC_DEF,
    parameter int unsigned HOLD_CYC    = SYNC_STAGES + 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [HUB_PORTS-1:0] sda_in,
    input  logic [HUB_PORTS-1:0] scl_in,
    input  logic [HUB_PORTS-2:0] port_en_req,
    output logic [HUB_PORTS-1:0] sda_pull,
    output logic [HUB_PORTS-1:0] scl_pull
);
    localparam int unsigned NLINES = 2;

    logic [NLINES*HUB_PORTS-1:0] raw_lvl, syn_lvl;
    port_vec_t                   lvl_arr [NLINES];
    port_vec_t                   drv_arr [NLINES];
    logic [NLINES-1:0]           busy;
    port_vec_t                   eff;

    assign raw_lvl = {scl_in, sda_in};

    hub_sync #(.WIDTH(NLINES*HUB_PORTS), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw_lvl),
        .q   (syn_lvl)
    );

    for (genvar l = 0; l < NLINES; l++) begin : g_line
        assign lvl_arr[l] = syn_lvl[l*HUB_PORTS +: HUB_PORTS];
        hub_line_ctrl #(.HOLD_CYC(HOLD_CYC)) u_ctrl (
            .clk   (clk),
            .rst   (rst),
            .lvl   (lvl_arr[l]),
            .en    (eff),
            .drive (drv_arr[l]),
            .busy  (busy[l])
        );
    end

    hub_en_qual u_qual (
        .clk      (clk),
        .rst      (rst),
        .req      (port_en_req),
        .sda_lvl  (lvl_arr[0]),
        .scl_lvl  (lvl_arr[1]),
        .sda_busy (busy[0]),
        .scl_busy (busy[1]),
        .eff      (eff)
    );

    assign sda_pull = drv_arr[0];
    assign scl_pull = drv_arr[1];

    // R7: a port without effective enable is never driven
    assert_disabled_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        ((sda_pull | scl_pull) & ~eff) == '0);
endmodule

// File: tb/i2c_hub_repeater_bench.sv
module i2c_hub_repeater_bench;
    import hub_pkg::*;

    logic      clk = 1'b0;
    logic      rst;
    port_vec_t dev_sda, dev_scl, sda_pull, scl_pull, sda_wire, scl_wire;
    logic [3:0] req;
    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #10 clk = ~clk;

    assign sda_wire = ~sda_pull & ~dev_sda;
    assign scl_wire = ~scl_pull & ~dev_scl;

    i2c_hub_repeater u_i2c_hub_repeater (
        .clk         (clk),
        .rst         (rst),
        .sda_in      (sda_wire),
        .scl_in      (scl_wire),
        .port_en_req (req),
        .sda_pull    (sda_pull),
        .scl_pull    (scl_pull)
    );

    task automatic tick(int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(string tag, port_vec_t act, port_vec_t exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    function automatic port_vec_t en_of(logic [3:0] r);
        return {r, 1'b1};
    endfunction

    function automatic port_vec_t pull_of(int line);
        return (line == 0) ? sda_pull : scl_pull;
    endfunction

    function automatic port_vec_t other_of(int line);
        return (line == 0) ? scl_pull : sda_pull;
    endfunction

    task automatic set_dev(int line, int p, bit v);
        if (line == 0) dev_sda[p] = v;
        else           dev_scl[p] = v;
    endtask

    task automatic settle();
        dev_sda = '0;
        dev_scl = '0;
        tick(10);
    endtask

    initial begin
        dev_sda = '0;
        dev_scl = '0;
        req     = '0;
        rst     = 1'b1;
        tick(3);
        chk("R1 in reset sda", sda_pull, '0);
        chk("R1 in reset scl", scl_pull, '0);
        rst = 1'b0;
        tick(1);
        chk("R1 after reset sda", sda_pull, '0);
        chk("R1 after reset scl", scl_pull, '0);

        // single-source sweep over every enable set, line and port
        for (int m = 0; m < 16; m++) begin
            req = 4'(m);
            settle();
            for (int line = 0; line < 2; line++) begin
                for (int p = 0; p < 5; p++) begin
                    port_vec_t em, exp;
                    string tag;
                    em  = en_of(4'(m));
                    exp = em[p] ? (em & ~(port_vec_t'(1) << p)) : '0;
                    tag = !em[p] ? "R7 disabled source" :
                          (p == 0) ? "R8 port0 source" : "R2 repeat";
                    set_dev(line, p, 1'b1);
                    tick(2);
                    chk("R2 not before third edge", pull_of(line), '0);
                    tick(1);
                    chk(tag, pull_of(line), exp);
                    chk("R3 other line untouched", other_of(line), '0);
                    set_dev(line, p, 1'b0);
                    tick(2);
                    chk("R4 held until third edge", pull_of(line), exp);
                    tick(1);
                    chk("R4 released", pull_of(line), '0);
                    tick(6);
                    chk("R5 no latch-up", pull_of(line), '0);
                end
            end
        end

        // simultaneous pulls and hand-off, all ports enabled
        req = 4'hF;
        settle();
        for (int a = 0; a < 5; a++) begin
            for (int b = a + 1; b < 5; b++) begin
                set_dev(0, a, 1'b1);
                set_dev(0, b, 1'b1);
                tick(3);
                chk("R6 lowest owns", sda_pull, 5'h1F & ~(port_vec_t'(1) << a));
                set_dev(0, a, 1'b0);
                tick(3);
                chk("R5 release before hand-off", sda_pull, '0);
                tick(3);
                chk("R5 hold-off masks driven port", sda_pull, '0);
                tick(1);
                chk("R5 hand-off to held port", sda_pull, 5'h1F & ~(port_vec_t'(1) << b));
                set_dev(0, b, 1'b0);
                tick(10);
                chk("R5 idle after hand-off", sda_pull, '0);
            end
        end

        // clock stretching on port 3 with an independent SDA low on port 1
        settle();
        dev_scl[3] = 1'b1;
        dev_sda[1] = 1'b1;
        tick(3);
        chk("R10 stretch start", scl_pull, 5'b10111);
        chk("R3 sda independent", sda_pull, 5'b11101);
        tick(300);
        chk("R10 stretch held", scl_pull, 5'b10111);
        dev_scl[3] = 1'b0;
        dev_sda[1] = 1'b0;
        tick(3);
        chk("R10 stretch end", scl_pull, '0);

        // enable request while busy is held
        req = 4'h0;
        settle();
        dev_sda[0] = 1'b1;
        tick(3);
        req = 4'b0010;
        tick(5);
        chk("R9 enable deferred while busy", sda_pull, '0);
        dev_sda[0] = 1'b0;
        tick(10);
        dev_sda[0] = 1'b1;
        tick(3);
        chk("R9 enable applied when idle", sda_pull, 5'b00100);
        req = 4'b0000;
        tick(5);
        chk("R9 disable deferred while busy", sda_pull, 5'b00100);
        dev_sda[0] = 1'b0;
        tick(10);
        dev_sda[0] = 1'b1;
        tick(3);
        chk("R9 disable applied when idle", sda_pull, '0);
        dev_sda[0] = 1'b0;
        tick(10);

        // enable request while the requested port's own line is low
        dev_scl[3] = 1'b1;
        tick(2);
        req = 4'b0100;
        tick(6);
        dev_sda[0] = 1'b1;
        tick(3);
        chk("R9 port line low blocks enable", sda_pull, '0);
        dev_sda[0] = 1'b0;
        dev_scl[3] = 1'b0;
        tick(10);
        dev_sda[0] = 1'b1;
        tick(3);
        chk("R9 enable after port idle", sda_pull, 5'b01000);
        dev_sda[0] = 1'b0;
        tick(10);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule